// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Status-Carrying FIFO

This block takes one asynchronous serial line and turns it into bytes for a host. A one-cycle enable pulse arrives at sixteen times the bit rate. The block uses it to find and qualify start bits, sample each bit near its centre and check parity and the stop bit. Each completed character goes into an eight-deep queue. The parity, framing and break flags of a character are stored in the same queue entry as its data. The host therefore always sees the flags of the character it is about to take.

When the queue is full, one more finished character waits in the assembly stage. Any character that completes after that replaces the waiting one and raises a sticky overrun flag. Characters already queued are never touched. When the host takes a character while one is waiting, the waiting character moves into the queue in the same cycle, so the full indication stays set. Character length and parity are set by static inputs. The bit-rate generator lives outside the block.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset, `rx_ready`, `fifo_full` and `overrun` are low.
- R2: A low line seen on a `tick16` pulse starts a frame. On the eighth pulse after that, the line is sampled again. If it is high there, the receiver returns to idle and no character is produced.
- R3: Data bits are received LSB first. `cfg_len` sets the length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits above the programmed length read as zero.
- R4: `cfg_par` selects the parity: 1 is even, 2 is odd, and 0 or 3 means no parity bit. `rd_perr` is set when the received parity bit does not match the selected parity.
- R5: A stop bit sampled low sets `rd_ferr` for that character.
- R6: `rd_brk` is set when every sampled data bit, the parity bit (if any) and the stop bit are low. After such a frame, no new start is accepted until the line has been seen high.
- R7: The queue holds 8 characters and returns them in arrival order. `rx_ready` is high while the queue is not empty. `fifo_full` is high while the queue holds 8 characters.
- R8: `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` always belong to the character at the head of the queue. Each character keeps its own flags.
- R9: A character that completes while the queue is full waits in the assembly stage. A later character that completes while one is waiting replaces it and sets `overrun`. The queued characters are kept unchanged.
- R10: A pop made while a character is waiting moves that character into the queue in the same cycle, and `fifo_full` stays high.
- R11: `overrun` stays set until `clr_err` is pulsed.
- R12: Suppose a character completes in the same cycle as a pop, while another character is waiting. Then the waiting character enters the queue, the new one becomes the waiting character, and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line input; idle high |
| cfg_len | input | 2 | Character length code (R3) |
| cfg_par | input | 2 | Parity mode code (R4) |
| rd_pop | input | 1 | Remove the head character |
| clr_err | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Data of the head character |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ferr | output | 1 | Framing error of the head character |
| rd_brk | output | 1 | Break flag of the head character |
| rx_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 8 characters |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two things can fall in the same cycle: a character completing its stop-bit sample, and a host pop of a full queue that also has a character waiting. The bench drives `tick16` itself, so it knows which pulse samples the stop bit. It raises `rd_pop` in the very next cycle, which is the cycle the completed character is offered to the queue. It then checks that `overrun` stayed low and `fifo_full` stayed high. Finally it drains the queue and checks that the old waiting character and the new one both come out, in order, after the original entries.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    function automatic int char_bits(input logic [1:0] len_code);
        return 5 + int'(len_code);
    endfunction

    function automatic logic parity_on(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic parity_bad(input logic [7:0] d, input logic pbit,
                                        input par_mode_e m);
        logic x;
        x = (^d) ^ pbit;
        return (m == PAR_ODD) ? ~x : x;
    endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic [1:0] cfg_len,
    input  par_mode_e cfg_par,
    output logic      done,
    output rx_char_t  ch
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [1:0]        sync_q;
    logic              rxd_s;
    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              seen_one;

    assign rxd_s    = sync_q[1];
    assign last_idx = BW'(char_bits(cfg_len) - 1);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            seen_one <= 1'b0;
            done     <= 1'b0;
            ch       <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            if (rxd_s) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_DATA;
                                bitn     <= '0;
                                shreg    <= '0;
                                par_bit  <= 1'b0;
                                seen_one <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            shreg[bitn] <= rxd_s;
                            seen_one    <= seen_one | rxd_s;
                            if (bitn == last_idx)
                                state <= parity_on(cfg_par) ? ST_PAR : ST_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            par_bit  <= rxd_s;
                            seen_one <= seen_one | rxd_s;
                            state    <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            ch.data <= shreg;
                            ch.perr <= parity_on(cfg_par) &&
                                       parity_bad(shreg, par_bit, cfg_par);
                            ch.ferr <= !rxd_s;
                            ch.brk  <= !rxd_s && !seen_one;
                            state   <= rxd_s ? ST_IDLE : ST_WAIT_HIGH;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAIT_HIGH: begin
                        if (rxd_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: a start that reads high at mid-bit goes back to idle
    a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && cnt == HALF && rxd_s) |=> state == ST_IDLE);

    // R6: after a low stop bit, no new frame starts while the line stays low
    a_r6_wait_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_HIGH && !rxd_s) |=> state == ST_WAIT_HIGH);

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t push_ch,
    input  logic     pop,
    output rx_char_t head,
    output logic     empty,
    output logic     full
);
    localparam int AW = $clog2(DEPTH);

    rx_char_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: never written past eight entries without a pop
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !(push && full && !pop));

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       rd_pop,
    input  logic       clr_err,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       rx_ready,
    output logic       fifo_full,
    output logic       overrun
);
    logic     char_done;
    rx_char_t new_ch;
    logic     hold_valid;
    rx_char_t hold_ch;
    logic     push;
    rx_char_t push_ch;
    rx_char_t head;
    logic     empty, full;
    logic     fifo_pop;

    srx_framer #(.OVS(OVS), .DATA_W(8)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rxd     (rxd),
        .cfg_len (cfg_len),
        .cfg_par (par_mode_e'(cfg_par)),
        .done    (char_done),
        .ch      (new_ch)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .push_ch (push_ch),
        .pop     (fifo_pop),
        .head    (head),
        .empty   (empty),
        .full    (full)
    );

    assign fifo_pop = rd_pop && !empty;

    always_comb begin
        push    = 1'b0;
        push_ch = new_ch;
        if (hold_valid && fifo_pop) begin
            push    = 1'b1;
            push_ch = hold_ch;
        end else if (!hold_valid && char_done && (!full || fifo_pop)) begin
            push    = 1'b1;
            push_ch = new_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_ch    <= '0;
            overrun    <= 1'b0;
        end else begin
            if (hold_valid) begin
                if (fifo_pop) hold_valid <= char_done;
                if (char_done) hold_ch <= new_ch;
            end else if (char_done && full && !fifo_pop) begin
                hold_valid <= 1'b1;
                hold_ch    <= new_ch;
            end
            if (hold_valid && char_done && !fifo_pop) overrun <= 1'b1;
            else if (clr_err)                         overrun <= 1'b0;
        end
    end

    assign rd_data   = head.data;
    assign rd_perr   = head.perr;
    assign rd_ferr   = head.ferr;
    assign rd_brk    = head.brk;
    assign rx_ready  = !empty;
    assign fifo_full = full;

    // R9: a character is only parked when the queue was full
    a_r9_hold_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_valid) |-> $past(full));

    // R10: popping with a parked character keeps the queue full
    a_r10_full_kept: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && rd_pop) |=> fifo_full);

    // R11: overrun is sticky until cleared
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_err) |=> overrun);

    // R12: completion coinciding with a pop does not raise overrun
    a_r12_no_ovr_on_pop: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && char_done && rd_pop && !overrun) |=> !overrun);

endmodule

// File: tb/serial_rx_channel_tb.sv
module serial_rx_channel_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick16;
    logic       rxd;
    logic [1:0] cfg_len;
    logic [1:0] cfg_par;
    logic       rd_pop;
    logic       clr_err;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic       rx_ready, fifo_full, overrun;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_rx_channel u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_pop(rd_pop), .clr_err(clr_err),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic one_tick(input bit pop_after);
        repeat (3) @(negedge clk);
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
        if (pop_after) begin
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
    endtask

    task automatic idle_ticks(input int n);
        rxd = 1'b1;
        for (int i = 0; i < n; i++) one_tick(1'b0);
    endtask

    // par_sel: 0 none, 1 even, 2 odd; flip inverts the parity bit
    task automatic send_frame(input logic [7:0] d, input int nd, input int par_sel,
                              input bit flip, input bit stop, input bit pop_at_done);
        logic pbit;
        logic [7:0] m;
        int nb;
        int stop_tick;
        m    = d & ((8'd1 << nd) - 8'd1);
        pbit = (par_sel == 2) ? ~(^m) : (^m);
        pbit = pbit ^ flip;
        nb   = nd + ((par_sel != 0) ? 1 : 0);
        stop_tick = 9 + 16 * (nb + 1);
        for (int k = 0; k < 16 * (nb + 2); k++) begin
            int slot;
            slot = k / 16;
            if (slot == 0)            rxd = 1'b0;
            else if (slot <= nd)      rxd = m[slot-1];
            else if (slot <= nb)      rxd = pbit;
            else                      rxd = stop;
            one_tick(pop_at_done && (k + 1 == stop_tick));
        end
        idle_ticks(3);
    endtask

    task automatic pop_head(output logic [7:0] d, output logic pe, output logic fe,
                            output logic bk);
        d = rd_data; pe = rd_perr; fe = rd_ferr; bk = rd_brk;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rx_ready", rx_ready, 0);
        check("R1 fifo_full", fifo_full, 0);
        check("R1 overrun", overrun, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic pe, fe, bk;
        cfg_len = 2'd3; cfg_par = 2'd0;
        send_frame(8'hA5, 8, 0, 0, 1, 0);
        check("R7 rx_ready set", rx_ready, 1);
        pop_head(d, pe, fe, bk);
        check("R3 8-bit data", d, 8'hA5);
        check("R5 no ferr", fe, 0);
        check("R7 empty after pop", rx_ready, 0);
    endtask

    task automatic t_lengths();
        logic [7:0] d; logic pe, fe, bk;
        cfg_len = 2'd0;
        send_frame(8'hF5, 5, 0, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R3 5-bit data upper zero", d, 8'h15);
        cfg_len = 2'd2;
        send_frame(8'hDA, 7, 0, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R3 7-bit data", d, 8'h5A);
        cfg_len = 2'd3;
    endtask

    task automatic t_parity();
        logic [7:0] d; logic pe, fe, bk;
        cfg_par = 2'd1;
        send_frame(8'h31, 8, 1, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R4 even good", pe, 0);
        check("R4 even data", d, 8'h31);
        send_frame(8'h31, 8, 1, 1, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R4 even bad", pe, 1);
        cfg_par = 2'd2;
        send_frame(8'h07, 8, 2, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R4 odd good", pe, 0);
        send_frame(8'h07, 8, 2, 1, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R4 odd bad", pe, 1);
        cfg_par = 2'd0;
    endtask

    task automatic t_framing_break();
        logic [7:0] d; logic pe, fe, bk;
        send_frame(8'h3C, 8, 0, 0, 0, 0);
        pop_head(d, pe, fe, bk);
        check("R5 ferr", fe, 1);
        check("R6 not break", bk, 0);
        send_frame(8'h00, 8, 0, 0, 0, 0);
        pop_head(d, pe, fe, bk);
        check("R6 break flag", bk, 1);
        check("R6 break ferr", fe, 1);
        check("R6 break data", d, 8'h00);
        check("R6 single entry", rx_ready, 0);
        send_frame(8'h42, 8, 0, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R6 recovery data", d, 8'h42);
    endtask

    task automatic t_false_start();
        rxd = 1'b0;
        for (int i = 0; i < 4; i++) one_tick(1'b0);
        idle_ticks(40);
        check("R2 glitch ignored", rx_ready, 0);
    endtask

    task automatic t_head_status();
        logic [7:0] d; logic pe, fe, bk;
        cfg_par = 2'd1;
        send_frame(8'h11, 8, 1, 1, 1, 0);
        send_frame(8'h22, 8, 1, 0, 1, 0);
        pop_head(d, pe, fe, bk);
        check("R8 first perr", pe, 1);
        check("R8 head perr", rd_perr, 0);
        check("R8 head data", rd_data, 8'h22);
        pop_head(d, pe, fe, bk);
        cfg_par = 2'd0;
    endtask

    task automatic t_overrun();
        logic [7:0] d; logic pe, fe, bk;
        for (int i = 0; i < 8; i++) send_frame(8'h10 + 8'(i), 8, 0, 0, 1, 0);
        check("R7 full at 8", fifo_full, 1);
        send_frame(8'h99, 8, 0, 0, 1, 0);
        check("R9 held no overrun", overrun, 0);
        send_frame(8'h77, 8, 0, 0, 1, 0);
        check("R9 overrun set", overrun, 1);
        pop_head(d, pe, fe, bk);
        check("R9 oldest kept", d, 8'h10);
        check("R10 full after pop", fifo_full, 1);
        for (int i = 1; i < 8; i++) begin
            pop_head(d, pe, fe, bk);
            check("R9 queue order", d, 8'h10 + 8'(i));
        end
        pop_head(d, pe, fe, bk);
        check("R9 newest replaced held", d, 8'h77);
        check("R7 drained", rx_ready, 0);
        check("R11 still set", overrun, 1);
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
        check("R11 cleared", overrun, 0);
    endtask

    task automatic t_coincide();
        logic [7:0] d; logic pe, fe, bk;
        for (int i = 0; i < 8; i++) send_frame(8'h20 + 8'(i), 8, 0, 0, 1, 0);
        send_frame(8'h55, 8, 0, 0, 1, 0);
        send_frame(8'h66, 8, 0, 0, 1, 1);
        check("R12 no overrun", overrun, 0);
        check("R12 still full", fifo_full, 1);
        for (int i = 1; i < 8; i++) begin
            pop_head(d, pe, fe, bk);
            check("R12 order", d, 8'h20 + 8'(i));
        end
        pop_head(d, pe, fe, bk);
        check("R12 old held", d, 8'h55);
        pop_head(d, pe, fe, bk);
        check("R12 new held", d, 8'h66);
        check("R12 drained", rx_ready, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; tick16 = 1'b0; rxd = 1'b1; cfg_len = 2'd3; cfg_par = 2'd0;
        rd_pop = 1'b0; clr_err = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        idle_ticks(2);
        t_basic();
        t_lengths();
        t_parity();
        t_framing_break();
        t_false_start();
        t_head_status();
        t_overrun();
        t_coincide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule